// File: doc/BRIEF.md
# Speculative Load Ordering Violation Detector

This block tracks loads that have executed ahead of older stores and are not yet committed. Each executed load leaves a record: its instruction number and the low bits of its address. When a store's address becomes known later, the block compares it with every record. If a load that is younger than the store touched a matching address, that load read stale data. The block then reports a violation that names the oldest such load, so the pipeline can squash from that point onward.

Program age is measured with wrap-around instruction numbers. Each number is taken relative to the instruction number at the commit head, which is supplied as an input. Committing a load releases its record. An abort releases every record at or after the abort point.

The address compare deliberately uses only the low address bits. This can raise a false alarm, but it can never miss a real one. When every record is in use, a stall output tells the pipeline to hold further loads.

Top module: `slb_viol_detect`

## Requirements
- R1: After reset no record is held: `full` is 0 and `viol_valid` is 0.
- R2: A store check whose address matches a held load that is younger than the store raises `viol_valid` with that load's number on `viol_inum`. This happens one clock after the check is presented.
- R3: A matching load that is older than the checked store raises no violation.
- R4: A load commit (`cm_valid`, `cm_inum`) releases that load's record, so later store checks no longer match it.
- R5: An abort (`ab_valid`, `ab_inum`) releases every record whose age is at least the age of `ab_inum`.
- R6: Only the low TAG_W address bits (default 12) take part in the compare. Addresses that differ only above bit TAG_W-1 still match.
- R7: When several younger loads match, `viol_inum` gives the one with the smallest age.
- R8: Age is the instruction number minus `head_inum`, modulo 2^INUM_W. Ordering stays correct when instruction numbers wrap past the largest value.
- R9: `full` is 1 while all ENTRIES records are held. A load presented while `full` is 1 is dropped, and no held record is overwritten.
- R10: A load presented in the same cycle as a store check takes part in that check.
- R11: A store whose low address bits match no held load raises no violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| head_inum | input | INUM_W | Instruction number at the commit head (age zero) |
| ld_valid | input | 1 | A load executes this cycle |
| ld_inum | input | INUM_W | Instruction number of the executing load |
| ld_addr | input | ADDR_W | Address of the executing load |
| cm_valid | input | 1 | A load commits this cycle |
| cm_inum | input | INUM_W | Instruction number of the committing load |
| ab_valid | input | 1 | Abort this cycle |
| ab_inum | input | INUM_W | Oldest instruction number that is discarded |
| st_valid | input | 1 | A store address is checked this cycle |
| st_inum | input | INUM_W | Instruction number of the store |
| st_addr | input | ADDR_W | Resolved store address |
| full | output | 1 | All records held; loads must stall |
| viol_valid | output | 1 | Ordering violation found by the previous check |
| viol_inum | output | INUM_W | Oldest offending load (squash point) |

## Verification
Two functions can fall in the same cycle: inserting a load and checking a store against the records. The bench provokes this by driving a load and a store with equal low address bits on the same clock edge, with the store older than the load. It judges the result by expecting a violation naming that load one cycle later. A scoreboard queue holds the expected outcome of every store check. A monitor compares each outcome with the violation outputs in the cycle after the check.

// File: rtl/slb_pkg.sv
package slb_pkg;
    localparam int SLB_ENTRIES = 8;
    localparam int SLB_INUM_W  = 6;
    localparam int SLB_ADDR_W  = 32;
    localparam int SLB_TAG_W   = 12;
endpackage

// File: rtl/slb_alloc.sv
module slb_alloc #(
    parameter int N     = slb_pkg::SLB_ENTRIES,
    localparam int IW   = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  vld,
    output logic [IW-1:0] free_idx,
    output logic          full
);
    always_comb begin
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!vld[i]) free_idx = IW'(i);
        end
        full = &vld;
    end
endmodule

// File: rtl/slb_match.sv
module slb_match #(
    parameter int N      = slb_pkg::SLB_ENTRIES,
    parameter int INUM_W = slb_pkg::SLB_INUM_W,
    parameter int TAG_W  = slb_pkg::SLB_TAG_W
) (
    input  logic [N-1:0]             vld,
    input  logic [N-1:0][INUM_W-1:0] inum,
    input  logic [N-1:0][TAG_W-1:0]  tag,
    input  logic                     new_v,
    input  logic [INUM_W-1:0]        new_inum,
    input  logic [TAG_W-1:0]         new_tag,
    input  logic [INUM_W-1:0]        head_inum,
    input  logic [INUM_W-1:0]        st_inum,
    input  logic [TAG_W-1:0]         st_tag,
    output logic                     hit,
    output logic [INUM_W-1:0]        hit_inum
);
    localparam int C = N + 1;

    logic [C-1:0]             c_v;
    logic [C-1:0][INUM_W-1:0] c_inum;
    logic [C-1:0][TAG_W-1:0]  c_tag;
    logic [C-1:0]             c_hit;

    assign c_v    = {new_v, vld};
    assign c_inum = {new_inum, inum};
    assign c_tag  = {new_tag, tag};

    logic [INUM_W-1:0] st_age;
    assign st_age = st_inum - head_inum;

    for (genvar g = 0; g < C; g++) begin : g_cmp
        logic [INUM_W-1:0] age;
        assign age      = c_inum[g] - head_inum;
        assign c_hit[g] = c_v[g] && (c_tag[g] == st_tag) && (age > st_age);
    end

    always_comb begin
        logic [INUM_W-1:0] best_age;
        logic [INUM_W-1:0] a;
        hit      = 1'b0;
        hit_inum = '0;
        best_age = '1;
        for (int i = 0; i < C; i++) begin
            a = c_inum[i] - head_inum;
            if (c_hit[i] && (!hit || a < best_age)) begin
                hit      = 1'b1;
                hit_inum = c_inum[i];
                best_age = a;
            end
        end
    end
endmodule

// File: rtl/slb_viol_detect.sv
module slb_viol_detect #(
    parameter int ENTRIES = slb_pkg::SLB_ENTRIES,
    parameter int INUM_W  = slb_pkg::SLB_INUM_W,
    parameter int ADDR_W  = slb_pkg::SLB_ADDR_W,
    parameter int TAG_W   = slb_pkg::SLB_TAG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [INUM_W-1:0] head_inum,
    input  logic              ld_valid,
    input  logic [INUM_W-1:0] ld_inum,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic              cm_valid,
    input  logic [INUM_W-1:0] cm_inum,
    input  logic              ab_valid,
    input  logic [INUM_W-1:0] ab_inum,
    input  logic              st_valid,
    input  logic [INUM_W-1:0] st_inum,
    input  logic [ADDR_W-1:0] st_addr,
    output logic              full,
    output logic              viol_valid,
    output logic [INUM_W-1:0] viol_inum
);
    localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    typedef struct packed {
        logic [ENTRIES-1:0]             vld;
        logic [ENTRIES-1:0][INUM_W-1:0] inum;
        logic [ENTRIES-1:0][TAG_W-1:0]  tag;
        logic                           viol_v;
        logic [INUM_W-1:0]              viol_inum;
    } state_t;

    state_t s_d, s_q;

    logic [IW-1:0]     free_idx;
    logic              hit;
    logic [INUM_W-1:0] hit_inum;
    logic              ins;
    logic [TAG_W-1:0]  ld_tag, st_tag;

    assign ld_tag = ld_addr[TAG_W-1:0];
    assign st_tag = st_addr[TAG_W-1:0];
    assign ins    = ld_valid && !full;

    slb_alloc #(.N(ENTRIES)) u_alloc (
        .vld      (s_q.vld),
        .free_idx (free_idx),
        .full     (full)
    );

    slb_match #(.N(ENTRIES), .INUM_W(INUM_W), .TAG_W(TAG_W)) u_match (
        .vld       (s_q.vld),
        .inum      (s_q.inum),
        .tag       (s_q.tag),
        .new_v     (ins),
        .new_inum  (ld_inum),
        .new_tag   (ld_tag),
        .head_inum (head_inum),
        .st_inum   (st_inum),
        .st_tag    (st_tag),
        .hit       (hit),
        .hit_inum  (hit_inum)
    );

    always_comb begin
        logic [INUM_W-1:0] ab_age;
        logic [INUM_W-1:0] e_age;
        s_d        = s_q;
        s_d.viol_v = 1'b0;
        ab_age     = ab_inum - head_inum;
        if (ins) begin
            s_d.vld[free_idx]  = 1'b1;
            s_d.inum[free_idx] = ld_inum;
            s_d.tag[free_idx]  = ld_tag;
        end
        if (st_valid) begin
            s_d.viol_v    = hit;
            s_d.viol_inum = hit ? hit_inum : s_q.viol_inum;
        end
        for (int i = 0; i < ENTRIES; i++) begin
            e_age = s_d.inum[i] - head_inum;
            if (cm_valid && s_d.inum[i] == cm_inum) s_d.vld[i] = 1'b0;
            if (ab_valid && e_age >= ab_age)        s_d.vld[i] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign viol_valid = s_q.viol_v;
    assign viol_inum  = s_q.viol_inum;

    // R9
    full_no_insert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && ld_valid && !cm_valid && !ab_valid) |=> full);

    // R2
    viol_from_check_chk: assert property (@(posedge clk) disable iff (!rst_n)
        viol_valid |-> $past(st_valid));

    // R3
    viol_younger_chk: assert property (@(posedge clk) disable iff (!rst_n)
        viol_valid |-> (INUM_W'(viol_inum - $past(head_inum)) >
                        INUM_W'($past(st_inum) - $past(head_inum))));

    // R5
    abort_head_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ab_valid && ab_inum == head_inum && !ld_valid) |=> (s_q.vld == '0));
endmodule

// File: tb/slb_viol_detect_tb.sv
module slb_viol_detect_tb;
    localparam int IN_W = 6;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [IN_W-1:0] head_inum = '0;
    logic            ld_valid = 1'b0;
    logic [IN_W-1:0] ld_inum = '0;
    logic [31:0]     ld_addr = '0;
    logic            cm_valid = 1'b0;
    logic [IN_W-1:0] cm_inum = '0;
    logic            ab_valid = 1'b0;
    logic [IN_W-1:0] ab_inum = '0;
    logic            st_valid = 1'b0;
    logic [IN_W-1:0] st_inum = '0;
    logic [31:0]     st_addr = '0;
    logic            full;
    logic            viol_valid;
    logic [IN_W-1:0] viol_inum;

    always #10ns clk = ~clk;

    slb_viol_detect u_dut (
        .clk(clk), .rst_n(rst_n), .head_inum(head_inum),
        .ld_valid(ld_valid), .ld_inum(ld_inum), .ld_addr(ld_addr),
        .cm_valid(cm_valid), .cm_inum(cm_inum),
        .ab_valid(ab_valid), .ab_inum(ab_inum),
        .st_valid(st_valid), .st_inum(st_inum), .st_addr(st_addr),
        .full(full), .viol_valid(viol_valid), .viol_inum(viol_inum)
    );

    typedef struct {
        bit    v;
        int    inum;
        string req;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 0;

    task automatic check(bit ok, string req, string what, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // monitor: pops one expectation per store check, one cycle later
    initial begin
        forever begin
            bit had;
            @(posedge clk);
            had = st_valid;
            @(negedge clk);
            if (had && exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check(viol_valid == e.v, e.req, "viol_valid", int'(viol_valid), int'(e.v));
                if (e.v) check(int'(viol_inum) == e.inum, e.req, "viol_inum", int'(viol_inum), e.inum);
            end
        end
    end

    task automatic do_load(int n, int a);
        ld_valid = 1'b1; ld_inum = IN_W'(n); ld_addr = 32'(a);
        @(negedge clk);
        ld_valid = 1'b0;
    endtask

    task automatic do_store(int n, int a, bit ev, int ei, string req);
        exp_t e;
        e.v = ev; e.inum = ei; e.req = req;
        exp_q.push_back(e);
        st_valid = 1'b1; st_inum = IN_W'(n); st_addr = 32'(a);
        @(negedge clk);
        st_valid = 1'b0;
    endtask

    task automatic do_commit(int n);
        cm_valid = 1'b1; cm_inum = IN_W'(n);
        @(negedge clk);
        cm_valid = 1'b0;
    endtask

    task automatic do_abort(int n);
        ab_valid = 1'b1; ab_inum = IN_W'(n);
        @(negedge clk);
        ab_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(20ns * 20000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(full == 1'b0, "R1", "full", int'(full), 0);
        check(viol_valid == 1'b0, "R1", "viol_valid", int'(viol_valid), 0);

        head_inum = 0;
        do_load(5, 'h1234);
        do_store(3, 'h1234, 1, 5, "R2");
        do_store(2, 'hABCD234, 1, 5, "R6");
        do_store(7, 'h1234, 0, 0, "R3");
        do_store(3, 'h1238, 0, 0, "R11");

        do_load(9, 'h5234);
        do_load(12, 'h300);
        do_load(10, 'h7300);
        do_store(4, 'h300, 1, 10, "R7");

        do_commit(5);
        do_store(3, 'h1234, 1, 9, "R4");

        do_abort(9);
        do_store(1, 'h1234, 0, 0, "R5");
        do_store(1, 'h300, 0, 0, "R5");

        // wrap-around ages
        head_inum = 60;
        do_load(2, 'h777);
        do_load(62, 'h777);
        do_store(61, 'h777, 1, 62, "R8");
        do_store(63, 'h777, 1, 2, "R8");
        do_abort(60);

        // full buffer
        head_inum = 0;
        for (int i = 0; i < 8; i++) do_load(10 + i, 'h100 + i);
        check(full == 1'b1, "R9", "full", int'(full), 1);
        do_load(18, 'h555);
        do_store(0, 'h555, 0, 0, "R9");
        do_store(0, 'h107, 1, 17, "R9");
        do_commit(10);
        check(full == 1'b0, "R9", "full after commit", int'(full), 0);
        do_abort(10);

        // same-cycle insert and check
        begin
            exp_t e;
            e.v = 1; e.inum = 20; e.req = "R10";
            exp_q.push_back(e);
            ld_valid = 1'b1; ld_inum = 20; ld_addr = 'h42;
            st_valid = 1'b1; st_inum = 19; st_addr = 'h9042;
            @(negedge clk);
            ld_valid = 1'b0; st_valid = 1'b0;
        end
        do_store(19, 'h42, 1, 20, "R10");

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R2", "pending checks", exp_q.size(), 0);
        finish_run();
    end
endmodule